// File: doc/BRIEF.md
# Dual Smart-Card Contact Power Sequencer

This block powers the contacts of two smart-card slots up and down in a fixed, staggered order. Each slot has its own sequencer. A sequencer is started by that slot's start bit and stopped when the bit is cleared. The contact enables (supply, data line, clock and reset drive) switch on one at a time, each at a set fraction of a base period T. They switch off in the reverse order. The two slots share one supply converter and one fast/slow oscillator request. The shared resource stays on while either slot needs it.

Timing is counted in sub-ticks. A sub-tick lasts `SUB_DIV` clock cycles, and T is 64 sub-ticks (`T_SUB`). Each sequencer has one counter that restarts when a sequence begins. The counter is compared against the step thresholds. There are four states:
- IDLE: contacts off.
- RAMP: activation in progress.
- ON: session running.
- DOWN: deactivation in progress.

The transitions are:
- IDLE to RAMP on a permitted start.
- RAMP to ON when the last activation step is reached.
- RAMP or ON to DOWN on a stop or a fault.
- DOWN to IDLE at the final teardown step.

Fault conditions force the same ordered teardown. Faults that belong to one slot affect only that slot. Chip-wide faults tear down both slots and clear both start bits through one-cycle strobes.

Top module: `dual_card_pwr_seq`

## Requirements
- R1: After reset every output is low.
- R2: A slot leaves IDLE only when all of the following hold: its start bit is high, the card is present, `supervisor_busy` is low, and none of its fault inputs is high. Until then a held start bit produces no output.
- R3: Let t0 be the edge that accepts a start. With `SUB_DIV`=1 and `T_SUB`=64, the outputs rise as follows:
  - `osc_fast` rises at t0.
  - `conv_en` rises one sub-tick later, at t1.
  - `vcc_on` rises at t1+96 sub-ticks.
  - `io_on` rises at t1+224.
  - `clk_on`, `rst_enable` and `card_active` rise together at t1+256.
- R4: Let t10 be the edge that sees the start bit low during a session, and t11 = t10+1 sub-tick. The outputs fall as follows:
  - `rst_enable` falls at t11.
  - `clk_on` falls at t11+32.
  - `io_on` falls at t11+64.
  - `vcc_on` falls at t11+96.
  - `card_active` and the slot's claim on converter and oscillator drop at t11+224.
- R5: `conv_en` and `osc_fast` are the OR of the two slots' claims. Ending one slot's session leaves them high while the other slot is active. They fall only at the teardown end of the last slot.
- R6: A stop or fault during RAMP moves to DOWN at once. Any enable not yet raised stays low, even when the stop lands on the edge where that enable would have risen.
- R7: A local fault on a slot in RAMP or ON tears down that slot only. Local faults are `vcc_overload`, `rst_overload`, and `card_present` falling. At t10 the slot pulses `start_clear` and `prot_flag` high for one cycle. A plain stop pulses neither.
- R8: A chip-wide fault tears down both slots and pulses both `start_clear` bits. `over_temp` also pulses both `prot_flag` bits. `supply_lost` and `conv_fault` do not pulse `prot_flag`.
- R9: Fault inputs that arrive while a slot is IDLE produce no strobe and no output change.
- R10: At every cycle, for each slot:
  - `rst_enable` implies `clk_on`;
  - `clk_on` implies `io_on`;
  - `io_on` implies `vcc_on`;
  - `vcc_on` implies `conv_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_start | input | N_CARDS | Per-slot start/stop bit |
| card_present | input | N_CARDS | Per-slot card presence |
| vcc_overload | input | N_CARDS | Per-slot supply overcurrent |
| rst_overload | input | N_CARDS | Per-slot reset-line overcurrent while driven low |
| supervisor_busy | input | 1 | Supply supervisor active; blocks activation |
| over_temp | input | 1 | Chip overtemperature |
| supply_lost | input | 1 | Supply drop-out |
| conv_fault | input | 1 | Converter out of range |
| conv_en | output | 1 | Shared converter enable |
| osc_fast | output | 1 | Shared oscillator high-speed request |
| vcc_on | output | N_CARDS | Card supply enable |
| io_on | output | N_CARDS | Data line enable |
| clk_on | output | N_CARDS | Card clock enable |
| rst_enable | output | N_CARDS | Reset contact driven (held low until answer logic raises it) |
| start_clear | output | N_CARDS | One-cycle strobe clearing the slot's start bit |
| prot_flag | output | N_CARDS | One-cycle strobe setting the slot's protection status |
| card_active | output | N_CARDS | Slot session active |

## Verification
Two events can fall on the same edge: a stop or fault, and an activation step that is due on that edge. The tests provoke this by aborting activation at the exact sub-tick before the supply step and before the final clock/reset step. They also abort at random points. In every case the enables must freeze at their pre-abort values and then fall on the teardown schedule.

The other coincidence is one slot's teardown end against the other slot's live session. Here the shared converter must stay up exactly until the last claim drops. This is judged by comparing every cycle against step functions computed from the timing requirements.

// File: rtl/cps_pkg.sv
package cps_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RAMP = 2'd1,
        SEQ_ON   = 2'd2,
        SEQ_DOWN = 2'd3
    } seq_state_t;
endpackage

// File: rtl/cps_tick_gen.sv
module cps_tick_gen #(
    parameter int SUB_DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (SUB_DIV <= 1) begin : g_direct
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tick <= 1'b0;
                else        tick <= 1'b1;
            end
        end else begin : g_div
            localparam int DW = $clog2(SUB_DIV);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                    tick  <= 1'b0;
                end else begin
                    tick <= (div_q == DW'(SUB_DIV - 1));
                    if (div_q == DW'(SUB_DIV - 1)) div_q <= '0;
                    else                           div_q <= div_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/cps_fault_sort.sv
module cps_fault_sort (
    input  logic present,
    input  logic vcc_ovl,
    input  logic rst_ovl,
    input  logic supv_busy,
    input  logic hot,
    input  logic lost,
    input  logic cfault,
    output logic kill,
    output logic prot_cause,
    output logic may_start
);
    logic local_hit;
    logic chip_hit;

    always_comb begin
        local_hit  = !present || vcc_ovl || rst_ovl;
        chip_hit   = hot || lost || cfault;
        kill       = local_hit || chip_hit;
        prot_cause = local_hit || hot;
        may_start  = present && !supv_busy && !kill;
    end
endmodule

// File: rtl/cps_card_fsm.sv
module cps_card_fsm
    import cps_pkg::*;
#(
    parameter int T_SUB = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic may_start,
    input  logic kill,
    input  logic prot_cause,
    output logic osc_req,
    output logic conv_req,
    output logic vcc_en,
    output logic io_en,
    output logic clk_en,
    output logic rst_en,
    output logic active,
    output logic clr_start,
    output logic prot_set
);
    localparam int UP_VCC  = (3 * T_SUB) / 2;
    localparam int UP_IO   = (7 * T_SUB) / 2;
    localparam int UP_LAST = 4 * T_SUB;
    localparam int DN_CLK  = T_SUB / 2;
    localparam int DN_IO   = T_SUB;
    localparam int DN_VCC  = (3 * T_SUB) / 2;
    localparam int DN_LAST = (7 * T_SUB) / 2;
    localparam int CW      = $clog2(UP_LAST + 1);

    seq_state_t    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          go_act, go_down;

    always_comb begin
        go_act  = (state == SEQ_IDLE) && start && may_start;
        go_down = ((state == SEQ_RAMP) || (state == SEQ_ON)) && (!start || kill);
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            SEQ_IDLE: begin
                if (go_act) begin
                    state_nx = SEQ_RAMP;
                    cnt_nx   = '0;
                end
            end
            SEQ_RAMP: begin
                if (go_down) begin
                    state_nx = SEQ_DOWN;
                    cnt_nx   = '0;
                end else if (tick) begin
                    if (cnt == CW'(UP_LAST)) state_nx = SEQ_ON;
                    else                     cnt_nx   = cnt + 1'b1;
                end
            end
            SEQ_ON: begin
                if (go_down) begin
                    state_nx = SEQ_DOWN;
                    cnt_nx   = '0;
                end
            end
            SEQ_DOWN: begin
                if (tick) begin
                    if (cnt == CW'(DN_LAST)) begin
                        state_nx = SEQ_IDLE;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            osc_req   <= 1'b0;
            conv_req  <= 1'b0;
            vcc_en    <= 1'b0;
            io_en     <= 1'b0;
            clk_en    <= 1'b0;
            rst_en    <= 1'b0;
            active    <= 1'b0;
            clr_start <= 1'b0;
            prot_set  <= 1'b0;
        end else begin
            clr_start <= go_down && kill;
            prot_set  <= go_down && prot_cause;
            if (go_act) begin
                osc_req <= 1'b1;
            end else if (go_down) begin
                // teardown begins; every enable holds until its own step
            end else if (state == SEQ_RAMP && tick) begin
                if (cnt == '0)              conv_req <= 1'b1;
                if (cnt == CW'(UP_VCC))     vcc_en   <= 1'b1;
                if (cnt == CW'(UP_IO))      io_en    <= 1'b1;
                if (cnt == CW'(UP_LAST)) begin
                    clk_en <= 1'b1;
                    rst_en <= 1'b1;
                    active <= 1'b1;
                end
            end else if (state == SEQ_DOWN && tick) begin
                if (cnt == '0)              rst_en <= 1'b0;
                if (cnt == CW'(DN_CLK))     clk_en <= 1'b0;
                if (cnt == CW'(DN_IO))      io_en  <= 1'b0;
                if (cnt == CW'(DN_VCC))     vcc_en <= 1'b0;
                if (cnt == CW'(DN_LAST)) begin
                    conv_req <= 1'b0;
                    osc_req  <= 1'b0;
                    active   <= 1'b0;
                end
            end
        end
    end

    // R10
    rst_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_en |-> clk_en);
    // R10
    clk_needs_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |-> io_en);
    // R10
    io_needs_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> vcc_en);
    // R10
    vcc_needs_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_en |-> conv_req && osc_req);
    // R7
    clear_in_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_start |-> state == SEQ_DOWN);
    // R8
    prot_with_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_set |-> clr_start);
    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(UP_LAST));
endmodule

// File: rtl/dual_card_pwr_seq.sv
module dual_card_pwr_seq #(
    parameter int N_CARDS = 2,
    parameter int SUB_DIV = 1,
    parameter int T_SUB   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CARDS-1:0] card_start,
    input  logic [N_CARDS-1:0] card_present,
    input  logic [N_CARDS-1:0] vcc_overload,
    input  logic [N_CARDS-1:0] rst_overload,
    input  logic               supervisor_busy,
    input  logic               over_temp,
    input  logic               supply_lost,
    input  logic               conv_fault,
    output logic               conv_en,
    output logic               osc_fast,
    output logic [N_CARDS-1:0] vcc_on,
    output logic [N_CARDS-1:0] io_on,
    output logic [N_CARDS-1:0] clk_on,
    output logic [N_CARDS-1:0] rst_enable,
    output logic [N_CARDS-1:0] start_clear,
    output logic [N_CARDS-1:0] prot_flag,
    output logic [N_CARDS-1:0] card_active
);
    logic               tick;
    logic [N_CARDS-1:0] conv_req;
    logic [N_CARDS-1:0] osc_req;

    cps_tick_gen #(.SUB_DIV(SUB_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    generate
        for (genvar g = 0; g < N_CARDS; g++) begin : g_card
            logic kill, prot_cause, may_start;

            cps_fault_sort u_sort (
                .present    (card_present[g]),
                .vcc_ovl    (vcc_overload[g]),
                .rst_ovl    (rst_overload[g]),
                .supv_busy  (supervisor_busy),
                .hot        (over_temp),
                .lost       (supply_lost),
                .cfault     (conv_fault),
                .kill       (kill),
                .prot_cause (prot_cause),
                .may_start  (may_start)
            );

            cps_card_fsm #(.T_SUB(T_SUB)) u_fsm (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick       (tick),
                .start      (card_start[g]),
                .may_start  (may_start),
                .kill       (kill),
                .prot_cause (prot_cause),
                .osc_req    (osc_req[g]),
                .conv_req   (conv_req[g]),
                .vcc_en     (vcc_on[g]),
                .io_en      (io_on[g]),
                .clk_en     (clk_on[g]),
                .rst_en     (rst_enable[g]),
                .active     (card_active[g]),
                .clr_start  (start_clear[g]),
                .prot_set   (prot_flag[g])
            );
        end
    endgenerate

    always_comb begin
        conv_en  = |conv_req;
        osc_fast = |osc_req;
    end

    // R5
    conv_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_en) |-> card_active == '0);
    // R5
    osc_covers_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_en |-> osc_fast);
endmodule

// File: tb/dual_card_pwr_seq_bench.sv
module dual_card_pwr_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] start_r, pres_r, vovl_r, rovl_r;
    logic       supv_r, hot_r, lost_r, cf_r;
    logic       conv_en, osc_fast;
    logic [1:0] vcc_on, io_on, clk_on, rst_enable, start_clear, prot_flag, card_active;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk;

    dual_card_pwr_seq u_dual_card_pwr_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .card_start      (start_r),
        .card_present    (pres_r),
        .vcc_overload    (vovl_r),
        .rst_overload    (rovl_r),
        .supervisor_busy (supv_r),
        .over_temp       (hot_r),
        .supply_lost     (lost_r),
        .conv_fault      (cf_r),
        .conv_en         (conv_en),
        .osc_fast        (osc_fast),
        .vcc_on          (vcc_on),
        .io_on           (io_on),
        .clk_on          (clk_on),
        .rst_enable      (rst_enable),
        .start_clear     (start_clear),
        .prot_flag       (prot_flag),
        .card_active     (card_active)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // bit order {active, rst, clk, io, vcc, conv, osc}
    function automatic logic [6:0] got_vec(input int c);
        return {card_active[c], rst_enable[c], clk_on[c], io_on[c], vcc_on[c], conv_en, osc_fast};
    endfunction

    function automatic logic [6:0] act_vec(input int k);
        logic [6:0] v;
        v[0] = (k >= 0);
        v[1] = (k >= 1);
        v[2] = (k >= 97);
        v[3] = (k >= 225);
        v[4] = (k >= 257);
        v[5] = (k >= 257);
        v[6] = (k >= 257);
        return v;
    endfunction

    function automatic logic [6:0] down_vec(input int k, input logic [6:0] v0);
        logic [6:0] v;
        v    = v0;
        v[5] = v0[5] && (k < 1);
        v[4] = v0[4] && (k < 33);
        v[3] = v0[3] && (k < 65);
        v[2] = v0[2] && (k < 97);
        v[1] = v0[1] && (k < 225);
        v[0] = v0[0] && (k < 225);
        v[6] = v0[6] && (k < 225);
        return v;
    endfunction

    function automatic logic order_ok();
        logic ok;
        ok = 1'b1;
        for (int c = 0; c < 2; c++) begin
            if (rst_enable[c] && !clk_on[c]) ok = 1'b0;
            if (clk_on[c] && !io_on[c])      ok = 1'b0;
            if (io_on[c] && !vcc_on[c])      ok = 1'b0;
            if (vcc_on[c] && !conv_en)       ok = 1'b0;
        end
        return ok;
    endfunction

    // kind: 0 stop, 1 supply overload, 2 reset overload, 3 removal
    task automatic session(input int c, input int abort_k, input int kind, input bit other_on);
        logic [6:0] v0;
        logic [6:0] om;
        string      tag;
        om = other_on ? 7'b0000011 : 7'b0;
        @(negedge clk);
        start_r[c] = 1'b1;
        @(posedge clk);
        for (int k = 0; k <= abort_k; k++) begin
            @(negedge clk);
            chk("R3", got_vec(c), act_vec(k) | om);
            chk("R10", order_ok(), 1'b1);
            if (k < abort_k) @(posedge clk);
        end
        v0 = act_vec(abort_k);
        case (kind)
            0: start_r[c] = 1'b0;
            1: vovl_r[c]  = 1'b1;
            2: rovl_r[c]  = 1'b1;
            default: pres_r[c] = 1'b0;
        endcase
        @(posedge clk);
        @(negedge clk);
        chk("R7", start_clear[c], kind != 0);
        chk("R7", prot_flag[c], kind != 0);
        chk("R7", start_clear[1-c], 1'b0);
        start_r[c] = 1'b0;
        vovl_r[c]  = 1'b0;
        rovl_r[c]  = 1'b0;
        tag = (abort_k < 257) ? "R6" : "R4";
        chk(tag, got_vec(c), down_vec(0, v0) | om);
        for (int k = 1; k <= 228; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk(tag, got_vec(c), down_vec(k, v0) | om);
            chk("R10", order_ok(), 1'b1);
        end
        pres_r[c] = 1'b1;
        chk("R7", card_active[1-c], other_on);
    endtask

    // kind: 1 over_temp, 2 supply_lost, 3 conv_fault
    task automatic chip_fault(input int kind);
        @(negedge clk);
        start_r = 2'b11;
        repeat (260) @(negedge clk);
        chk("R8", card_active, 2'b11);
        hot_r  = (kind == 1);
        lost_r = (kind == 2);
        cf_r   = (kind == 3);
        @(posedge clk);
        @(negedge clk);
        chk("R8", start_clear, 2'b11);
        chk("R8", prot_flag, (kind == 1) ? 2'b11 : 2'b00);
        chk("R8", {rst_enable, clk_on}, 4'b1111);
        start_r = 2'b00;
        hot_r = 1'b0; lost_r = 1'b0; cf_r = 1'b0;
        @(negedge clk);
        chk("R8", rst_enable, 2'b00);
        repeat (230) @(negedge clk);
        chk("R8", {card_active, vcc_on, conv_en, osc_fast}, 6'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20231));
        rst_n = 1'b0;
        start_r = 2'b00; pres_r = 2'b11; vovl_r = 2'b00; rovl_r = 2'b00;
        supv_r = 1'b0; hot_r = 1'b0; lost_r = 1'b0; cf_r = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {conv_en, osc_fast, vcc_on, io_on, clk_on, rst_enable,
                   start_clear, prot_flag, card_active}, 16'h0);

        // R9 faults while idle
        vovl_r[0] = 1'b1; hot_r = 1'b1; pres_r[1] = 1'b0;
        @(negedge clk);
        vovl_r[0] = 1'b0; hot_r = 1'b0; pres_r[1] = 1'b1;
        chk("R9", {start_clear, prot_flag}, 4'b0);
        @(negedge clk);
        chk("R9", {start_clear, prot_flag, got_vec(0), got_vec(1)}, 18'h0);

        // R2 gating
        pres_r[0] = 1'b0; start_r[0] = 1'b1;
        repeat (5) begin @(negedge clk); chk("R2", got_vec(0), 7'b0); end
        pres_r[0] = 1'b1; supv_r = 1'b1;
        repeat (5) begin @(negedge clk); chk("R2", got_vec(0), 7'b0); end
        supv_r = 1'b0; rovl_r[0] = 1'b1;
        repeat (3) begin @(negedge clk); chk("R2", got_vec(0), 7'b0); end
        rovl_r[0] = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R2", osc_fast, 1'b1);
        start_r[0] = 1'b0;
        repeat (240) @(negedge clk);
        chk("R2", {got_vec(0), start_clear}, 9'b0);

        // directed sessions
        session(0, 300, 0, 1'b0);   // full activation then stop
        session(0, 0, 0, 1'b0);     // abort on entry
        session(0, 96, 0, 1'b0);    // abort on the supply step edge
        session(0, 256, 0, 1'b0);   // abort on the completion edge
        session(1, 300, 1, 1'b0);   // supply overload in session
        session(0, 150, 2, 1'b0);   // reset overload mid-ramp
        session(1, 400, 3, 1'b0);   // removal in session

        // R5 shared converter
        @(negedge clk);
        start_r[1] = 1'b1;
        repeat (260) @(negedge clk);
        chk("R5", card_active[1], 1'b1);
        session(0, 300, 0, 1'b1);
        session(0, 200, 1, 1'b1);
        chk("R5", {conv_en, osc_fast}, 2'b11);
        @(negedge clk);
        start_r[1] = 1'b0;
        @(posedge clk);
        repeat (224) @(posedge clk);
        @(negedge clk);
        chk("R5", {conv_en, osc_fast, card_active[1]}, 3'b111);
        @(posedge clk);
        @(negedge clk);
        chk("R5", {conv_en, osc_fast, card_active[1]}, 3'b000);

        // R8 chip-wide faults
        chip_fault(1);
        chip_fault(2);
        chip_fault(3);

        // random sessions
        for (int i = 0; i < 8; i++) begin
            int c, ak, kd;
            c  = $urandom_range(0, 1);
            ak = $urandom_range(0, 320);
            kd = $urandom_range(0, 3);
            session(c, ak, kd, 1'b0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule